// File: doc/BRIEF.md
# Prescaler and Divider Tick Generator

This block turns one clock into five per-channel count enables for a multi-channel timer. It has two 8-bit prescalers, one per channel group, and each divides the clock by its programmed value plus one. Channels 0 and 1 take their ticks from the first prescaler. Channels 2, 3 and 4 take theirs from the second.

Each channel has a 4-bit select code. A code either divides its group's prescaled tick by a further power of two, or hands the channel to the group's external tick input. For external ticks, one pulse is produced for each rising edge.

Prescale and select values are held in shadow registers. A new value is picked up only at a period boundary, so the period already running always finishes at its old length. Every enable is registered and lasts one clock cycle, so the timer counters can use it directly as a count enable.

Top module: `timer_tick_gen`

## Requirements
- R1: While rst_ni is low, every bit of tick_o is 0, and all counters and shadow registers are cleared.
- R2: cfg_pre_i[7:0] sets prescale value P of group 0 and cfg_pre_i[15:8] sets group 1. A group emits one prescaled tick every P+1 clocks.
- R3: Channels 0 and 1 count group 0 ticks. Channels 2, 3 and 4 count group 1 ticks. A channel in divide mode only ticks the cycle after a prescaled tick of its own group.
- R4: Channel c reads its select code S from cfg_sel_i[4c+3:4c]. If bit S of EXT_MASK is clear, the channel ticks once every 2^(S+DIV_BASE) group ticks.
- R5: The division ratio saturates at 16, whatever the size of S+DIV_BASE.
- R6: With DIV_BASE=1, code 0 divides by 2 and every other code divides by twice its DIV_BASE=0 ratio, up to the limit in R5.
- R7: If bit S of EXT_MASK is set, prescaled ticks are ignored. The channel ticks once for each rising edge of ext_tick_i[group], in the clock cycle after the first cycle ext_tick_i is seen high. An input held high gives one tick only.
- R8: When the total ratio (P+1)·2^k is 1, the channel's tick_o is high on every cycle.
- R9: In all other cases tick_o is a pulse exactly one cycle wide.
- R10: A new prescale value is used from the next prescaler wrap. A new select code is used from the end of the divided period in progress, or from the next prescaled tick while the channel is external. The period in progress keeps its old length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timer clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_pre_i | input | 16 | Prescale values, one byte per group |
| cfg_sel_i | input | 20 | Select codes, one nibble per channel |
| ext_tick_i | input | 2 | Synchronous external tick inputs, one per group |
| tick_o | output | 5 | Single-cycle count enables, one per channel |

## Verification
The bench builds two copies side by side from the same inputs:
- One uses the defaults, DIV_BASE=0 with codes 5 to 7 external.
- The other uses DIV_BASE=1 with only code 4 external.

The first copy reaches ratio 1 and codes 8 and up, which saturate at 16. The second shows the shifted ratios. Because the copies decode the same nibbles differently, the second also shows that external routing follows the mask and not a fixed code. Prescale and select changes are made right after a tick, so each change lands in the middle of a period.

// File: rtl/tick_gen_pkg.sv
package tick_gen_pkg;
  localparam int unsigned NUM_GRP = 2;

  function automatic int unsigned grp_of(input int unsigned ch, input int unsigned grp0_ch);
    return (ch < grp0_ch) ? 0 : 1;
  endfunction
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] div_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q, lim_q;

  assign tick_o = (cnt_q == lim_q);

  // shadow limit reloads only at wrap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (tick_o) begin
      cnt_q <= '0;
      lim_q <= div_i;
    end else begin
      cnt_q <= cnt_q + W'(1);
    end
  end
endmodule

// File: rtl/tick_edge_pulse.sv
module tick_edge_pulse (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_i,
  output logic pulse_o
);
  logic ext_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ext_q <= 1'b0;
    else         ext_q <= ext_i;
  end

  assign pulse_o = ext_i & ~ext_q;
endmodule

// File: rtl/tick_channel.sv
module tick_channel #(
  parameter int unsigned SEL_W    = 4,
  parameter int unsigned DIV_BASE = 0,
  parameter int unsigned MAX_LOG2 = 4,
  parameter logic [(1<<SEL_W)-1:0] EXT_MASK = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             pre_tick_i,
  input  logic             ext_pulse_i,
  output logic             ext_mode_o,
  output logic             tick_o
);
  localparam int unsigned CNT_W = (MAX_LOG2 < 1) ? 1 : MAX_LOG2;

  logic [SEL_W-1:0] act_q;
  logic [CNT_W-1:0] dcnt_q, lim;
  logic [SEL_W:0]   k_raw, k_sat;
  logic [CNT_W:0]   span;
  logic             div_tick, tick_q;

  always_comb begin
    k_raw = {1'b0, act_q} + (SEL_W+1)'(DIV_BASE);
    k_sat = (k_raw > (SEL_W+1)'(MAX_LOG2)) ? (SEL_W+1)'(MAX_LOG2) : k_raw;
    span  = (CNT_W+1)'(1) << k_sat;
    lim   = CNT_W'(span - (CNT_W+1)'(1));
  end

  assign ext_mode_o = EXT_MASK[act_q];
  assign div_tick   = pre_tick_i && (dcnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= '0;
      dcnt_q <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= ext_mode_o ? ext_pulse_i : div_tick;
      if (pre_tick_i) begin
        // select reloads only at a period boundary
        if (ext_mode_o || dcnt_q == lim) begin
          dcnt_q <= '0;
          act_q  <= sel_i;
        end else begin
          dcnt_q <= dcnt_q + CNT_W'(1);
        end
      end
    end
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/timer_tick_gen.sv
module timer_tick_gen
  import tick_gen_pkg::*;
#(
  parameter int unsigned NUM_CH   = 5,
  parameter int unsigned GRP0_CH  = 2,
  parameter int unsigned PRE_W    = 8,
  parameter int unsigned SEL_W    = 4,
  parameter int unsigned DIV_BASE = 0,
  parameter int unsigned MAX_LOG2 = 4,
  parameter logic [(1<<SEL_W)-1:0] EXT_MASK = 16'h00E0
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_GRP*PRE_W-1:0]  cfg_pre_i,
  input  logic [NUM_CH*SEL_W-1:0]   cfg_sel_i,
  input  logic [NUM_GRP-1:0]        ext_tick_i,
  output logic [NUM_CH-1:0]         tick_o
);
  logic [NUM_GRP-1:0] pre_tick, ext_pulse;
  logic [NUM_CH-1:0]  ext_mode;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    tick_prescaler #(.W(PRE_W)) i_pre (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .div_i  (cfg_pre_i[g*PRE_W +: PRE_W]),
      .tick_o (pre_tick[g])
    );
    tick_edge_pulse i_edge (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .ext_i   (ext_tick_i[g]),
      .pulse_o (ext_pulse[g])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int unsigned G = grp_of(c, GRP0_CH);
    tick_channel #(
      .SEL_W    (SEL_W),
      .DIV_BASE (DIV_BASE),
      .MAX_LOG2 (MAX_LOG2),
      .EXT_MASK (EXT_MASK)
    ) i_ch (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .sel_i       (cfg_sel_i[c*SEL_W +: SEL_W]),
      .pre_tick_i  (pre_tick[G]),
      .ext_pulse_i (ext_pulse[G]),
      .ext_mode_o  (ext_mode[c]),
      .tick_o      (tick_o[c])
    );
  end
endmodule

// File: rtl/tick_gen_chk.sv
module tick_gen_chk
  import tick_gen_pkg::*;
#(
  parameter int unsigned NUM_CH  = 5,
  parameter int unsigned GRP0_CH = 2,
  parameter int unsigned PRE_W   = 8
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [NUM_GRP*PRE_W-1:0] cfg_pre_i,
  input logic [NUM_GRP-1:0]       ext_i,
  input logic [NUM_GRP-1:0]       pre_tick_i,
  input logic [NUM_CH-1:0]        ext_mode_i,
  input logic [NUM_CH-1:0]        tick_i
);
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic [PRE_W:0]   gap_q;
    logic [PRE_W-1:0] lim_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        gap_q <= '0;
        lim_q <= '0;
      end else if (pre_tick_i[g]) begin
        gap_q <= '0;
        lim_q <= cfg_pre_i[g*PRE_W +: PRE_W];
      end else begin
        gap_q <= gap_q + (PRE_W+1)'(1);
      end
    end

    assert_pre_spacing_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pre_tick_i[g] == (gap_q == {1'b0, lim_q}));
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int unsigned G = grp_of(c, GRP0_CH);

    assert_div_on_own_pre_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i[c] && !$past(ext_mode_i[c])) |-> $past(pre_tick_i[G]));

    assert_ext_held_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(ext_mode_i[c]) && $past(ext_i[G], 2)) |-> !tick_i[c]);

    assert_back_to_back_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i[c] && $past(tick_i[c]) && !$past(ext_mode_i[c]) && !$past(ext_mode_i[c], 2))
        |-> ($past(pre_tick_i[G]) && $past(pre_tick_i[G], 2)));
  end
endmodule

bind timer_tick_gen tick_gen_chk #(
  .NUM_CH  (NUM_CH),
  .GRP0_CH (GRP0_CH),
  .PRE_W   (PRE_W)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_pre_i  (cfg_pre_i),
  .ext_i      (ext_tick_i),
  .pre_tick_i (pre_tick),
  .ext_mode_i (ext_mode),
  .tick_i     (tick_o)
);

// File: tb/test_timer_tick_gen.sv
module test_timer_tick_gen;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_pre = '0;
  logic [19:0] cfg_sel = '0;
  logic [1:0]  ext = '0;
  logic [4:0]  tick_a, tick_b;
  int total = 0, fails = 0;
  int cnt_a[5], cnt_b[5];

  always #(CLK_PERIOD/2) clk = ~clk;

  timer_tick_gen i_timer_tick_gen (
    .clk_i(clk), .rst_ni(rst_n), .cfg_pre_i(cfg_pre), .cfg_sel_i(cfg_sel),
    .ext_tick_i(ext), .tick_o(tick_a));

  timer_tick_gen #(.DIV_BASE(1), .EXT_MASK(16'h0010)) i_timer_tick_gen_b (
    .clk_i(clk), .rst_ni(rst_n), .cfg_pre_i(cfg_pre), .cfg_sel_i(cfg_sel),
    .ext_tick_i(ext), .tick_o(tick_b));

  function automatic logic tk(int ch, bit b);
    return b ? tick_b[ch] : tick_a[ch];
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_sel(int ch, logic [3:0] code);
    cfg_sel[ch*4 +: 4] = code;
  endtask

  task automatic wait_tick(int ch, bit b);
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (tk(ch, b)) return;
    end
    chk(1'b0, "timeout", 0, 1);
  endtask

  task automatic interval(int ch, bit b, output int n);
    n = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      n++;
      if (tk(ch, b)) return;
    end
  endtask

  task automatic period_of(int ch, bit b, output int n);
    wait_tick(ch, b);
    wait_tick(ch, b);
    interval(ch, b, n);
  endtask

  task automatic count_win(int cycles);
    for (int c = 0; c < 5; c++) begin cnt_a[c] = 0; cnt_b[c] = 0; end
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      for (int c = 0; c < 5; c++) begin
        cnt_a[c] += tick_a[c];
        cnt_b[c] += tick_b[c];
      end
    end
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(tick_a == 0, "R1 reset a", tick_a, 0);
    chk(tick_b == 0, "R1 reset b", tick_b, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_prescale;
    int n;
    cfg_pre = {8'd5, 8'd3};
    cfg_sel = '0;
    repeat (50) @(negedge clk);
    period_of(0, 0, n); chk(n == 4, "R2 grp0 P=3", n, 4);
    @(negedge clk);     chk(tick_a[0] == 0, "R9 width", tick_a[0], 0);
    period_of(1, 0, n); chk(n == 4, "R3 ch1 on grp0", n, 4);
    period_of(3, 0, n); chk(n == 6, "R3 ch3 on grp1 P=5", n, 6);
    period_of(0, 1, n); chk(n == 8, "R6 base1 code0", n, 8);
  endtask

  task automatic t_select;
    int n;
    set_sel(1, 4'd1); set_sel(2, 4'd8); set_sel(4, 4'd2);
    repeat (200) @(negedge clk);
    period_of(1, 0, n); chk(n == 8,  "R4 ch1 code1", n, 8);
    period_of(4, 0, n); chk(n == 24, "R4 ch4 code2", n, 24);
    period_of(2, 0, n); chk(n == 96, "R5 code8 saturates", n, 96);
    period_of(4, 1, n); chk(n == 48, "R6 base1 code2", n, 48);
    period_of(1, 1, n); chk(n == 16, "R6 base1 code1", n, 16);
  endtask

  task automatic t_external;
    set_sel(0, 4'd5); set_sel(2, 4'd6); set_sel(3, 4'd4);
    repeat (200) @(negedge clk);
    count_win(30);
    chk(cnt_a[0] == 0, "R7 prescale ignored ch0", cnt_a[0], 0);
    chk(cnt_a[2] == 0, "R7 prescale ignored ch2", cnt_a[2], 0);
    chk(cnt_b[3] == 0, "R7 mask code4 ignored", cnt_b[3], 0);
    ext[0] = 1'b1;
    @(negedge clk);
    chk(tick_a[0] == 1, "R7 edge latency", tick_a[0], 1);
    count_win(10);
    chk(cnt_a[0] == 0, "R7 held high once", cnt_a[0], 0);
    chk(cnt_a[2] == 0, "R7 ext0 not on grp1", cnt_a[2], 0);
    ext[0] = 1'b0;
    @(negedge clk);
    ext[1] = 1'b1;
    count_win(10);
    chk(cnt_a[2] == 1, "R7 ext1 ch2", cnt_a[2], 1);
    chk(cnt_b[3] == 1, "R7 ext1 base1 code4", cnt_b[3], 1);
    chk(cnt_a[0] == 0, "R7 ext1 not on grp0", cnt_a[0], 0);
    ext[1] = 1'b0;
  endtask

  task automatic t_ratio_one;
    int hi;
    cfg_sel = '0;
    cfg_pre[7:0] = 8'd0;
    repeat (200) @(negedge clk);
    hi = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      hi += tick_a[1];
    end
    chk(hi == 6, "R8 ratio one", hi, 6);
  endtask

  task automatic t_update;
    int n;
    cfg_pre[7:0] = 8'd9;
    repeat (50) @(negedge clk);
    wait_tick(1, 0);
    cfg_pre[7:0] = 8'd1;
    interval(1, 0, n); chk(n == 10, "R10 old prescale completes", n, 10);
    interval(1, 0, n); chk(n == 2,  "R10 new prescale", n, 2);
    set_sel(1, 4'd2);
    interval(1, 0, n); chk(n == 2,  "R10 old select completes", n, 2);
    interval(1, 0, n); chk(n == 8,  "R10 new select", n, 8);
  endtask

  initial begin
    t_reset();
    t_prescale();
    t_select();
    t_external();
    t_ratio_one();
    t_update();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule